// File: doc/BRIEF.md
# Trilinear Texel Cache with Parity-Banked Storage

This block is a read-only texel cache that sits between a texture filter and the texture memory. In a single cycle it can serve one full trilinear footprint. That footprint is a 2x2 texel quad on each of two adjacent mipmap levels, eight texels in all. Storage is divided into two groups of four banks. Lines of even mipmap levels live in one group and lines of odd levels in the other. Inside a line, texels are spread over the four banks of the group by the parity of their u and v coordinates. Any 2x2 quad therefore lands on four different banks. This holds even when the quad straddles a line boundary.

The filter presents up to eight lookups per cycle on eight request lanes. Each lookup carries a line address, the level parity and the texel's u and v offsets inside the line. Each lane receives its own hit flag and texel one cycle later. Misses are reported with a clear hit flag, and the missing line is loaded through a separate fill port that writes a whole line in one cycle. Every set holds two ways with one least-recently-used bit, so two lines that share a set can stay resident together. Texture data is never written by rendering, so the block keeps no dirty state and needs no coherence logic.

Top module: `texel_cache_tri`

## Requirements
- R1: After reset every line is invalid: every lookup misses, and all response outputs are 0 until a request is made.
- R2: A lookup's bank is {level parity, v[0], u[0]}, and its word inside that bank is {v[OFF_W-1:1], u[OFF_W-1:1]}. The fill word for texel (u,v) sits at slot v*2^OFF_W+u of `fill_data`. A hit returns exactly the texel that the last fill of that line wrote at (u,v).
- R3: Up to eight lanes are looked up in the same cycle. Lane k's response appears on lane k of the outputs in the cycle after the request.
- R4: A valid lookup that misses returns `rsp_valid`=1, `rsp_hit`=0 and `rsp_data`=0 on its lane.
- R5: The set index is the low log2(SETS) bits of the line address and the tag is the remaining bits. Two lines of the same group that share a set are both resident at once.
- R6: Even-parity and odd-parity lines are held apart. The same line address filled at both parities gives two independent lines, and filling one parity does not make the other hit.
- R7: Each set has one LRU bit. A fill goes into the way it names, and a hit or a fill sets it to point at the other way. When several banks of one group hit the same set in one cycle, the updates apply in ascending bank order, so the highest bank wins.
- R8: A fill of a line that is already resident rewrites that line's own way, replaces its data and leaves the other way's line resident.
- R9: A fill and a lookup of the same line in the same cycle behave fill-first: the lookup hits and returns the newly filled texel.
- R10: Among the lanes that are valid in one cycle, no two may carry the same bank code.
- R11: A lane with no valid request shows `rsp_valid`=0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 8 | Per-lane lookup valid |
| req_line | input | 8*LINE_W | Per-lane line address, lane k at bits [k*LINE_W +: LINE_W] |
| req_lvl | input | 8 | Per-lane mipmap level parity |
| req_u | input | 8*OFF_W | Per-lane u offset inside the line |
| req_v | input | 8*OFF_W | Per-lane v offset inside the line |
| fill_valid | input | 1 | Line fill strobe |
| fill_lvl | input | 1 | Level parity of the filled line |
| fill_line | input | LINE_W | Line address of the filled line |
| fill_data | input | 4^OFF_W*WORD_W | Whole line, texel (u,v) at slot v*2^OFF_W+u |
| rsp_valid | output | 8 | Per-lane response valid, one cycle after request |
| rsp_hit | output | 8 | Per-lane hit flag |
| rsp_data | output | 8*WORD_W | Per-lane texel, zero on a miss |

## Verification
The bench builds the cache with LINE_W=8, SETS=4, OFF_W=2 and WORD_W=16, so each line is a 4x4 texel block and the line addresses fall into only four sets with six-bit tags. With so few sets and a small pool of line addresses, the random traffic keeps colliding in sets and evicting lines. This exercises LRU victim choice, refills of resident lines, fill-and-lookup collisions in the same cycle, and hits from several banks on one set, all within a few hundred cycles. Every random cycle assigns the eight lanes a shuffled set of distinct bank codes, so lane-to-bank routing is tested for arbitrary permutations and not only for the identity mapping.

// File: rtl/texcache_pkg.sv
package texcache_pkg;

    localparam int NUM_LANES       = 8;
    localparam int NUM_BANKS       = 8;
    localparam int BANKS_PER_GROUP = 4;

    // Bank selected by a texel: level parity picks the group, texel parity picks the bank in it.
    function automatic logic [2:0] texel_bank(input logic lvl, input logic v0, input logic u0);
        return {lvl, v0, u0};
    endfunction

endpackage

// File: rtl/texcache_tag_copy.sv
module texcache_tag_copy #(
    parameter int SETS  = 16,
    parameter int TAG_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fill_en,
    input  logic [$clog2(SETS)-1:0]  fill_set,
    input  logic                     fill_way,
    input  logic [TAG_W-1:0]         fill_tag,
    input  logic [$clog2(SETS)-1:0]  lk_set,
    input  logic [TAG_W-1:0]         lk_tag,
    output logic                     lk_hit,
    output logic                     lk_way,
    output logic                     pre_hit,
    output logic                     pre_way
);

    typedef struct packed {
        logic [SETS-1:0][1:0]            vld;
        logic [SETS-1:0][1:0][TAG_W-1:0] tag;
    } tag_state_t;

    tag_state_t st_d, st_q;
    logic [1:0] way_hit;
    logic [1:0] pre_match;

    always_comb begin
        st_d = st_q;
        if (fill_en) begin
            st_d.vld[fill_set][fill_way] = 1'b1;
            st_d.tag[fill_set][fill_way] = fill_tag;
        end
        // lookup sees the state after this cycle's fill
        for (int w = 0; w < 2; w++) begin
            way_hit[w]   = st_d.vld[lk_set][w] && (st_d.tag[lk_set][w] == lk_tag);
            pre_match[w] = st_q.vld[fill_set][w] && (st_q.tag[fill_set][w] == fill_tag);
        end
        lk_hit  = |way_hit;
        lk_way  = way_hit[1];
        pre_hit = |pre_match;
        pre_way = pre_match[1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // a line never sits in both ways of a set
    p_single_way_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(way_hit) && $onehot0(pre_match));

    // a fill leaves its tag valid in the chosen way
    p_fill_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> st_q.vld[$past(fill_set)][$past(fill_way)] &&
                    (st_q.tag[$past(fill_set)][$past(fill_way)] == $past(fill_tag)));

endmodule

// File: rtl/texcache_data_slice.sv
module texcache_data_slice #(
    parameter int SETS   = 16,
    parameter int WPB    = 4,
    parameter int WORD_W = 16
) (
    input  logic                      clk,
    input  logic                      fill_en,
    input  logic [$clog2(SETS)-1:0]   fill_set,
    input  logic                      fill_way,
    input  logic [WPB*WORD_W-1:0]     fill_words,
    input  logic [$clog2(SETS)-1:0]   rd_set,
    input  logic                      rd_way,
    input  logic [$clog2(WPB)-1:0]    rd_idx,
    output logic [WORD_W-1:0]         rd_data
);

    localparam int SET_W = $clog2(SETS);
    localparam int IDX_W = $clog2(WPB);
    localparam int DEPTH = SETS * 2 * WPB;

    logic [WORD_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (fill_en) begin
            for (int i = 0; i < WPB; i++) begin
                mem_q[{fill_set, fill_way, IDX_W'(i)}] <= fill_words[i*WORD_W +: WORD_W];
            end
        end
    end

    always_comb begin
        if (fill_en && (fill_set == rd_set) && (fill_way == rd_way))
            rd_data = fill_words[rd_idx*WORD_W +: WORD_W];
        else
            rd_data = mem_q[{rd_set, rd_way, rd_idx}];
    end

    logic [SET_W-1:0] unused_w;
    assign unused_w = '0;

endmodule

// File: rtl/texel_cache_tri.sv
module texel_cache_tri
    import texcache_pkg::*;
#(
    parameter int LINE_W = 12,
    parameter int SETS   = 16,
    parameter int OFF_W  = 2,
    parameter int WORD_W = 16
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [7:0]                            req_valid,
    input  logic [8*LINE_W-1:0]                   req_line,
    input  logic [7:0]                            req_lvl,
    input  logic [8*OFF_W-1:0]                    req_u,
    input  logic [8*OFF_W-1:0]                    req_v,
    input  logic                                  fill_valid,
    input  logic                                  fill_lvl,
    input  logic [LINE_W-1:0]                     fill_line,
    input  logic [(1<<(2*OFF_W))*WORD_W-1:0]      fill_data,
    output logic [7:0]                            rsp_valid,
    output logic [7:0]                            rsp_hit,
    output logic [8*WORD_W-1:0]                   rsp_data
);

    localparam int SET_W  = $clog2(SETS);
    localparam int TAG_W  = LINE_W - SET_W;
    localparam int EDGE   = 1 << OFF_W;
    localparam int TEXELS = EDGE * EDGE;
    localparam int WPB    = TEXELS / BANKS_PER_GROUP;
    localparam int HALF_W = OFF_W - 1;
    localparam int IDX_W  = 2 * HALF_W;

    typedef struct packed {
        logic [1:0][SETS-1:0]              lru;
        logic [NUM_LANES-1:0]              vld;
        logic [NUM_LANES-1:0]              hit;
        logic [NUM_LANES-1:0][WORD_W-1:0]  dat;
    } cache_state_t;

    cache_state_t st_d, st_q;

    // lane decode
    logic [2:0]       lane_bank [NUM_LANES];
    logic [SET_W-1:0] lane_set  [NUM_LANES];
    logic [TAG_W-1:0] lane_tag  [NUM_LANES];
    logic [IDX_W-1:0] lane_idx  [NUM_LANES];

    // per-bank routed request
    logic [NUM_LANES-1:0] bank_sel [NUM_BANKS];
    logic                 bank_act [NUM_BANKS];
    logic [SET_W-1:0]     bank_set [NUM_BANKS];
    logic [TAG_W-1:0]     bank_tag [NUM_BANKS];
    logic [IDX_W-1:0]     bank_idx [NUM_BANKS];
    logic                 bank_hit [NUM_BANKS];
    logic                 bank_way [NUM_BANKS];
    logic [WORD_W-1:0]    bank_dat [NUM_BANKS];
    logic                 pre_hit  [NUM_BANKS];
    logic                 pre_way  [NUM_BANKS];
    logic [WPB*WORD_W-1:0] bank_fill_words [NUM_BANKS];

    logic [SET_W-1:0] fill_set;
    logic [TAG_W-1:0] fill_tag;
    logic             fill_way;

    assign fill_set = fill_line[SET_W-1:0];
    assign fill_tag = fill_line[LINE_W-1:SET_W];

    always_comb begin
        for (int k = 0; k < NUM_LANES; k++) begin
            lane_bank[k] = texel_bank(req_lvl[k], req_v[k*OFF_W], req_u[k*OFF_W]);
            lane_set[k]  = req_line[k*LINE_W +: SET_W];
            lane_tag[k]  = req_line[k*LINE_W + SET_W +: TAG_W];
            lane_idx[k]  = {req_v[k*OFF_W+1 +: HALF_W], req_u[k*OFF_W+1 +: HALF_W]};
        end
    end

    // lane-to-bank crossbar, request side
    always_comb begin
        for (int b = 0; b < NUM_BANKS; b++) begin
            bank_sel[b] = '0;
            bank_act[b] = 1'b0;
            bank_set[b] = '0;
            bank_tag[b] = '0;
            bank_idx[b] = '0;
            for (int k = 0; k < NUM_LANES; k++) begin
                if (req_valid[k] && (lane_bank[k] == 3'(b))) begin
                    bank_sel[b][k] = 1'b1;
                    bank_act[b]    = 1'b1;
                    bank_set[b]    = bank_set[b] | lane_set[k];
                    bank_tag[b]    = bank_tag[b] | lane_tag[k];
                    bank_idx[b]    = bank_idx[b] | lane_idx[k];
                end
            end
        end
    end

    // scatter a filled line over the four banks of its group
    always_comb begin
        for (int b = 0; b < NUM_BANKS; b++) begin
            bank_fill_words[b] = '0;
            for (int i = 0; i < WPB; i++) begin
                int uu, vv;
                uu = ((i % (1 << HALF_W)) * 2) + (b % 2);
                vv = ((i / (1 << HALF_W)) * 2) + ((b / 2) % 2);
                bank_fill_words[b][i*WORD_W +: WORD_W] = fill_data[(vv*EDGE + uu)*WORD_W +: WORD_W];
            end
        end
    end

    // victim: the resident way on a refill, else the way the LRU bit names
    always_comb begin
        if (pre_hit[{fill_lvl, 2'b00}]) fill_way = pre_way[{fill_lvl, 2'b00}];
        else                             fill_way = st_q.lru[fill_lvl][fill_set];
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic fill_here;
        assign fill_here = fill_valid && (fill_lvl == 1'(b / BANKS_PER_GROUP));

        texcache_tag_copy #(.SETS(SETS), .TAG_W(TAG_W)) tag_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .fill_en  (fill_here),
            .fill_set (fill_set),
            .fill_way (fill_way),
            .fill_tag (fill_tag),
            .lk_set   (bank_set[b]),
            .lk_tag   (bank_tag[b]),
            .lk_hit   (bank_hit[b]),
            .lk_way   (bank_way[b]),
            .pre_hit  (pre_hit[b]),
            .pre_way  (pre_way[b])
        );

        texcache_data_slice #(.SETS(SETS), .WPB(WPB), .WORD_W(WORD_W)) data_i (
            .clk        (clk),
            .fill_en    (fill_here),
            .fill_set   (fill_set),
            .fill_way   (fill_way),
            .fill_words (bank_fill_words[b]),
            .rd_set     (bank_set[b]),
            .rd_way     (bank_way[b]),
            .rd_idx     (bank_idx[b]),
            .rd_data    (bank_dat[b])
        );
    end

    // next state: LRU (fill first, then hits by ascending bank) and lane responses
    always_comb begin
        st_d = st_q;
        if (fill_valid) st_d.lru[fill_lvl][fill_set] = ~fill_way;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_act[b] && bank_hit[b])
                st_d.lru[b / BANKS_PER_GROUP][bank_set[b]] = ~bank_way[b];
        end
        for (int k = 0; k < NUM_LANES; k++) begin
            st_d.vld[k] = req_valid[k];
            st_d.hit[k] = req_valid[k] && bank_hit[lane_bank[k]];
            st_d.dat[k] = st_d.hit[k] ? bank_dat[lane_bank[k]] : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.vld;
    assign rsp_hit   = st_q.hit;
    assign rsp_data  = st_q.dat;

    // ---------------- assertions ----------------
    logic group_hit_on_fill_set;
    always_comb begin
        group_hit_on_fill_set = 1'b0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_act[b] && bank_hit[b] && (1'(b / BANKS_PER_GROUP) == fill_lvl) &&
                (bank_set[b] == fill_set))
                group_hit_on_fill_set = 1'b1;
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
        p_code_unique_r10: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(bank_sel[b]) <= 1);
        p_copies_agree_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (pre_hit[b] == pre_hit[(b / BANKS_PER_GROUP) * BANKS_PER_GROUP]) &&
            (!pre_hit[b] || (pre_way[b] == pre_way[(b / BANKS_PER_GROUP) * BANKS_PER_GROUP])));
    end

    p_rsp_needs_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit & ~$past(req_valid)) == 8'h00);

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid == 8'h00) |=> (rsp_valid == 8'h00));

    p_lru_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !group_hit_on_fill_set) |=>
            (st_q.lru[$past(fill_lvl)][$past(fill_set)] == ~$past(fill_way)));

endmodule

// File: tb/texel_cache_tri_tb.sv
module texel_cache_tri_tb_top;

    localparam int LW = 8;
    localparam int NS = 4;
    localparam int OW = 2;
    localparam int WW = 16;
    localparam int TW = 6;
    localparam int ED = 4;
    localparam int TX = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [7:0]        req_valid = '0;
    logic [8*LW-1:0]   req_line = '0;
    logic [7:0]        req_lvl = '0;
    logic [8*OW-1:0]   req_u = '0;
    logic [8*OW-1:0]   req_v = '0;
    logic              fill_valid = 1'b0;
    logic              fill_lvl = 1'b0;
    logic [LW-1:0]     fill_line = '0;
    logic [TX*WW-1:0]  fill_data = '0;
    logic [7:0]        rsp_valid;
    logic [7:0]        rsp_hit;
    logic [8*WW-1:0]   rsp_data;

    always #4 clk = ~clk;

    texel_cache_tri #(.LINE_W(LW), .SETS(NS), .OFF_W(OW), .WORD_W(WW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_line(req_line), .req_lvl(req_lvl),
        .req_u(req_u), .req_v(req_v),
        .fill_valid(fill_valid), .fill_lvl(fill_lvl), .fill_line(fill_line),
        .fill_data(fill_data),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data)
    );

    int total = 0;
    int bad = 0;

    // bench-side stimulus
    bit           l_vld [8];
    bit           l_lvl [8];
    int           l_line[8];
    int           l_u   [8];
    int           l_v   [8];
    bit           f_vld;
    bit           f_lvl;
    int           f_line;
    logic [WW-1:0] f_words [TX];

    // reference model
    bit            m_val [2][NS][2];
    int            m_tag [2][NS][2];
    logic [WW-1:0] m_dat [2][NS][2][TX];
    bit            m_lru [2][NS];
    bit            e_vld [8];
    bit            e_hit [8];
    logic [WW-1:0] e_dat [8];

    function automatic int code_of(int k);
        return (l_lvl[k] ? 4 : 0) + ((l_v[k] % 2) * 2) + (l_u[k] % 2);
    endfunction

    task automatic check(string tag, string what, int k, longint got, longint exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s lane %0d %s: got %0h exp %0h", tag, k, what, got, exp);
        end
    endtask

    task automatic clear_stim();
        for (int k = 0; k < 8; k++) l_vld[k] = 1'b0;
        f_vld = 1'b0;
    endtask

    task automatic set_lane(int k, int line, bit lvl, int u, int v);
        l_vld[k] = 1'b1; l_line[k] = line; l_lvl[k] = lvl; l_u[k] = u; l_v[k] = v;
    endtask

    task automatic set_fill(int line, bit lvl);
        f_vld = 1'b1; f_line = line; f_lvl = lvl;
        for (int t = 0; t < TX; t++) f_words[t] = WW'($urandom);
    endtask

    task automatic model_cycle();
        if (f_vld) begin
            int g, s, t, w;
            g = f_lvl; s = f_line % NS; t = f_line / NS; w = -1;
            for (int ww = 0; ww < 2; ww++)
                if (m_val[g][s][ww] && m_tag[g][s][ww] == t) w = ww;
            if (w < 0) w = m_lru[g][s];
            m_val[g][s][w] = 1'b1;
            m_tag[g][s][w] = t;
            for (int i = 0; i < TX; i++) m_dat[g][s][w][i] = f_words[i];
            m_lru[g][s] = (w == 0);
        end
        for (int k = 0; k < 8; k++) begin
            e_vld[k] = l_vld[k]; e_hit[k] = 1'b0; e_dat[k] = '0;
        end
        for (int b = 0; b < 8; b++) begin
            for (int k = 0; k < 8; k++) begin
                if (l_vld[k] && code_of(k) == b) begin
                    int g, s, t;
                    g = l_lvl[k]; s = l_line[k] % NS; t = l_line[k] / NS;
                    for (int w = 0; w < 2; w++) begin
                        if (m_val[g][s][w] && m_tag[g][s][w] == t) begin
                            e_hit[k] = 1'b1;
                            e_dat[k] = m_dat[g][s][w][l_v[k]*ED + l_u[k]];
                            m_lru[g][s] = (w == 0);
                        end
                    end
                end
            end
        end
    endtask

    task automatic drive_ports();
        for (int k = 0; k < 8; k++) begin
            req_valid[k]          = l_vld[k];
            req_line[k*LW +: LW]  = LW'(l_line[k]);
            req_lvl[k]            = l_lvl[k];
            req_u[k*OW +: OW]     = OW'(l_u[k]);
            req_v[k*OW +: OW]     = OW'(l_v[k]);
        end
        fill_valid = f_vld;
        fill_lvl   = f_lvl;
        fill_line  = LW'(f_line);
        for (int t = 0; t < TX; t++) fill_data[t*WW +: WW] = f_words[t];
    endtask

    // called just after a falling edge; checks at the next falling edge
    task automatic run_cycle(string tag);
        drive_ports();
        model_cycle();
        @(posedge clk);
        @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            check(tag, "valid", k, rsp_valid[k], e_vld[k]);
            if (e_vld[k]) begin
                check(tag, "hit", k, rsp_hit[k], e_hit[k]);
                check(tag, "data", k, rsp_data[k*WW +: WW], e_dat[k]);
            end
        end
        clear_stim();
        drive_ports();
    endtask

    // read the 16 texels of one line over four cycles, lanes 0..3 by bank
    task automatic read_line(int line, bit lvl, string tag);
        for (int c = 0; c < 4; c++) begin
            for (int j = 0; j < 4; j++)
                set_lane(j + (lvl ? 4 : 0), line, lvl, ((c % 2) * 2) + (j % 2), ((c / 2) * 2) + (j / 2));
            run_cycle(tag);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: got timeout exp finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    int pool [8] = '{5, 9, 13, 17, 6, 10, 2, 21};

    initial begin
        void'($urandom(32'd20240611));
        for (int g = 0; g < 2; g++)
            for (int s = 0; s < NS; s++) begin
                m_lru[g][s] = 1'b0;
                for (int w = 0; w < 2; w++) begin m_val[g][s][w] = 1'b0; m_tag[g][s][w] = 0; end
            end
        clear_stim();
        for (int t = 0; t < TX; t++) f_words[t] = '0;
        drive_ports();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", "valid", 0, rsp_valid, 0);
        check("R1", "hit", 0, rsp_hit, 0);
        check("R1", "data", 0, rsp_data, 0);

        // R1 R4: lookups into an empty cache all miss with zero data
        for (int b = 0; b < 8; b++) set_lane(7 - b, 5, b / 4, b % 2, (b / 2) % 2);
        run_cycle("R1 R4");

        // R2: placement of a filled line
        set_fill(5, 0); run_cycle("R2");
        read_line(5, 0, "R2");

        // R6: same address at odd parity, then both groups in one cycle (R3)
        set_lane(4, 5, 1, 1, 1); run_cycle("R6");
        set_fill(5, 1); run_cycle("R6");
        for (int j = 0; j < 4; j++) begin
            set_lane(j, 5, 0, 2 + (j % 2), j / 2);
            set_lane(j + 4, 5, 1, j % 2, 2 + (j / 2));
        end
        run_cycle("R3 R6");

        // R5: second line of set 1 in group 0; odd parity of it stays absent
        set_fill(9, 0); run_cycle("R5");
        set_lane(0, 5, 0, 0, 0); set_lane(1, 9, 0, 1, 0);
        set_lane(6, 9, 1, 0, 1); run_cycle("R5 R6");
        set_lane(2, 9, 0, 2, 1); set_lane(3, 5, 0, 3, 3); run_cycle("R5");

        // R7: LRU victim choice
        set_fill(13, 0); run_cycle("R7");
        set_lane(0, 5, 0, 0, 0); set_lane(1, 9, 0, 1, 0); set_lane(2, 13, 0, 0, 1);
        run_cycle("R7");
        // R7: two banks hit one set with different ways, highest bank wins
        set_lane(5, 9, 0, 0, 0); set_lane(3, 13, 0, 1, 1); run_cycle("R7");
        set_fill(17, 0); run_cycle("R7");
        set_lane(0, 9, 0, 2, 2); set_lane(1, 13, 0, 3, 0); set_lane(2, 17, 0, 0, 3);
        run_cycle("R7");

        // R9: fill and lookup of the same line in one cycle
        set_fill(6, 0);
        for (int j = 0; j < 4; j++) set_lane(j, 6, 0, (j % 2) + 2, (j / 2) + 2);
        run_cycle("R9");

        // R8: refill a resident line, its set mate stays
        set_fill(17, 0); run_cycle("R8");
        set_lane(0, 17, 0, 0, 0); set_lane(1, 13, 0, 1, 0); run_cycle("R8");
        set_lane(2, 9, 0, 0, 1); set_lane(3, 17, 0, 3, 3); run_cycle("R8");

        // R11: idle cycle
        run_cycle("R11");

        // R3 R10: random traffic, distinct bank codes per cycle
        for (int n = 0; n < 400; n++) begin
            int perm [8];
            for (int i = 0; i < 8; i++) perm[i] = i;
            for (int i = 7; i > 0; i--) begin
                int j, tmp;
                j = $urandom_range(i, 0);
                tmp = perm[i]; perm[i] = perm[j]; perm[j] = tmp;
            end
            for (int k = 0; k < 8; k++) begin
                if ($urandom_range(3, 0) != 0)
                    set_lane(k, pool[$urandom_range(7, 0)], perm[k] / 4,
                             ((($urandom_range(1, 0)) * 2) + (perm[k] % 2)),
                             ((($urandom_range(1, 0)) * 2) + ((perm[k] / 2) % 2)));
            end
            if ($urandom_range(9, 0) < 3) set_fill(pool[$urandom_range(7, 0)], 1'($urandom_range(1, 0)));
            run_cycle("R3 R10");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule